// File: doc/BRIEF.md
# Serial Channel Flow Controller

This block performs automatic flow control for a single full-duplex asynchronous serial channel. It sits between the receive path and the receive FIFO, and between the transmit queue and the transmit shifter. The shifters, the baud timing and the FIFOs are outside the block. The block sees them only as strobes, a character bus, a fill-level input and a launch pulse.

With in-band control enabled, the block compares every received character with two programmable codes, one for stop and one for resume. A stop code halts the launching of queued transmit data and a resume code releases it, with no host action. Both codes are consumed and never reach the receive FIFO. The host can request that a stop or resume code be sent to the far end. Such a request goes ahead of queued data and is sent even while the local transmitter is halted.

With out-of-band control enabled, the block raises its request-to-send line whenever it has something to send. It launches no character unless clear-to-send is high. Separately, a data-terminal-ready line tracks the receive FIFO fill level against a programmable threshold of 1 to 8 characters.

Top module: `sfc_flow_ctrl`

## Requirements
- R1: With `cfg_inband_en`=1, a received character equal to `cfg_xoff_char` halts the transmitter. From the next clock edge on, no queued data character is launched (`txq_pop` stays 0). A character already being shifted out is not affected.
- R2: With `cfg_inband_en`=1, a received character equal to `cfg_xon_char` (and not equal to `cfg_xoff_char`) clears the halt. Queued data then resumes in queue order.
- R3: With `cfg_inband_en`=1, a received stop or resume code is not forwarded (`rx_fifo_wr`=0 in that cycle). Every other received character is forwarded in the same cycle, with `rx_fifo_data` equal to `rx_char`.
- R4: With `cfg_inband_en`=0, stop and resume codes are forwarded like any other character and do not halt the transmitter. Clearing `cfg_inband_en` also clears any halt.
- R5: A pulse on `cmd_send_xoff` or `cmd_send_xon` makes the block launch that code (`tx_char`=`cfg_xoff_char` or `cfg_xon_char`) before any queued data. The code is launched even while halted. The code is launched without a `txq_pop`. If both commands pulse together, the stop code is sent.
- R6: With `cfg_rts_cts_en`=1, no character of any kind is launched while `cts_in`=0. With `cfg_rts_cts_en`=0, `cts_in` has no effect.
- R7: With `cfg_rts_cts_en`=1, `rts_out` is 1 one cycle after a character is pending, launching or being shifted. `rts_out` is 0 when nothing is pending. With `cfg_rts_cts_en`=0, `rts_out` is always 0.
- R8: With `cfg_dtr_en`=1, one cycle after `rx_level` is sampled, `dtr_out` is 1 if `rx_level` is below the threshold and 0 otherwise. The threshold is `cfg_rx_thresh` limited to the range 1 to 8 (0 acts as 1, values above 8 act as 8). With `cfg_dtr_en`=0, `dtr_out` is held at 1.
- R9: `tx_start` is a one-cycle pulse and `txq_pop` pulses in the same cycle for a data launch. No launch is decided while `tx_busy`=1 or while `tx_start`=1. The shifter must raise `tx_busy` in the cycle after `tx_start`.
- R10: After reset, `tx_start`, `txq_pop`, `rts_out` and `dtr_out` are 0, the halt is cleared and no host command is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_inband_en | input | 1 | Enable in-band stop/resume handling |
| cfg_rts_cts_en | input | 1 | Enable request/clear-to-send handshake |
| cfg_dtr_en | input | 1 | Enable threshold control of DTR |
| cfg_xon_char | input | 8 | Resume code |
| cfg_xoff_char | input | 8 | Stop code |
| cfg_rx_thresh | input | 4 | Receive fill threshold (1 to 8) |
| rx_valid | input | 1 | Received character strobe |
| rx_char | input | 8 | Received character |
| rx_fifo_wr | output | 1 | Write strobe toward receive FIFO |
| rx_fifo_data | output | 8 | Character toward receive FIFO |
| rx_level | input | 4 | Receive FIFO fill level |
| cmd_send_xon | input | 1 | Host request: send resume code |
| cmd_send_xoff | input | 1 | Host request: send stop code |
| txq_valid | input | 1 | Transmit queue has a character |
| txq_data | input | 8 | Head of transmit queue |
| txq_pop | output | 1 | Removes head of transmit queue |
| tx_busy | input | 1 | Transmit shifter busy |
| tx_start | output | 1 | Launch pulse to the shifter |
| tx_char | output | 8 | Character to shift out |
| cts_in | input | 1 | Clear-to-send, active high |
| rts_out | output | 1 | Request-to-send, active high |
| dtr_out | output | 1 | Data-terminal-ready, active high |

## Verification
A stuck halt register shows at the ports in one of two ways. A halt that never sets lets queued data keep popping a cycle after a stop code arrives. A halt that never clears leaves the queue frozen after a resume code. A lost or mis-prioritised host request shows up as the wrong first character after clear-to-send rises, or as a spurious `txq_pop` on a code launch. A wrong threshold limit flips `dtr_out` one cycle after the level input changes. A broken launch guard shows as two `tx_start` pulses for one queue entry within three cycles.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int DATA_W  = 8;
  localparam int LVL_W   = 4;
  localparam int FIFO_DEPTH = 8;

  // Threshold limited to 1..FIFO_DEPTH
  function automatic logic [LVL_W-1:0] eff_thresh(input logic [LVL_W-1:0] t);
    if (t == '0) return LVL_W'(1);
    if (int'(t) > FIFO_DEPTH) return LVL_W'(FIFO_DEPTH);
    return t;
  endfunction

  function automatic logic code_hit(input logic en, input logic vld,
                                    input logic [DATA_W-1:0] a,
                                    input logic [DATA_W-1:0] b);
    return en && vld && (a == b);
  endfunction
endpackage

// File: rtl/sfc_inband.sv
module sfc_inband
  import sfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DATA_W-1:0] xon_char,
  input  logic [DATA_W-1:0] xoff_char,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_char,
  output logic              fwd_wr,
  output logic [DATA_W-1:0] fwd_data,
  output logic              hit_xon,
  output logic              hit_xoff,
  output logic              halted
);
  assign hit_xoff = code_hit(en, rx_valid, rx_char, xoff_char);
  assign hit_xon  = code_hit(en, rx_valid, rx_char, xon_char) && !hit_xoff;
  assign fwd_wr   = rx_valid && !hit_xoff && !hit_xon;
  assign fwd_data = rx_char;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        halted <= 1'b0;
    else if (!en)      halted <= 1'b0;
    else if (hit_xoff) halted <= 1'b1;
    else if (hit_xon)  halted <= 1'b0;
  end
endmodule

// File: rtl/sfc_tx_sched.sv
module sfc_tx_sched
  import sfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halted,
  input  logic              rts_cts_en,
  input  logic              cts_in,
  input  logic              cmd_xon,
  input  logic              cmd_xoff,
  input  logic [DATA_W-1:0] xon_char,
  input  logic [DATA_W-1:0] xoff_char,
  input  logic              txq_valid,
  input  logic [DATA_W-1:0] txq_data,
  input  logic              tx_busy,
  output logic              tx_start,
  output logic [DATA_W-1:0] tx_char,
  output logic              txq_pop,
  output logic              rts_out,
  output logic              launch_data,
  output logic              launch_spec,
  output logic              pend_valid
);
  logic pend_is_xoff;
  logic line_ok, slot_free;

  assign line_ok     = !rts_cts_en || cts_in;
  assign slot_free   = !tx_busy && !tx_start;
  assign launch_spec = slot_free && line_ok && pend_valid;
  assign launch_data = slot_free && line_ok && !pend_valid && txq_valid && !halted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid   <= 1'b0;
      pend_is_xoff <= 1'b0;
    end else if (cmd_xon || cmd_xoff) begin
      pend_valid   <= 1'b1;
      pend_is_xoff <= cmd_xoff;
    end else if (launch_spec) begin
      pend_valid   <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_start <= 1'b0;
      txq_pop  <= 1'b0;
      tx_char  <= '0;
      rts_out  <= 1'b0;
    end else begin
      tx_start <= launch_spec || launch_data;
      txq_pop  <= launch_data;
      if (launch_spec)      tx_char <= pend_is_xoff ? xoff_char : xon_char;
      else if (launch_data) tx_char <= txq_data;
      rts_out  <= rts_cts_en && (txq_valid || pend_valid || tx_busy || tx_start);
    end
  end
endmodule

// File: rtl/sfc_dtr_ctl.sv
module sfc_dtr_ctl
  import sfc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [LVL_W-1:0] thresh,
  input  logic [LVL_W-1:0] level,
  output logic             dtr_out
);
  logic [LVL_W-1:0] lim;
  assign lim = eff_thresh(thresh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dtr_out <= 1'b0;
    else        dtr_out <= en ? (level < lim) : 1'b1;
  end
endmodule

// File: rtl/sfc_flow_ctrl.sv
module sfc_flow_ctrl
  import sfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_inband_en,
  input  logic              cfg_rts_cts_en,
  input  logic              cfg_dtr_en,
  input  logic [DATA_W-1:0] cfg_xon_char,
  input  logic [DATA_W-1:0] cfg_xoff_char,
  input  logic [LVL_W-1:0]  cfg_rx_thresh,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_char,
  output logic              rx_fifo_wr,
  output logic [DATA_W-1:0] rx_fifo_data,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic              cmd_send_xon,
  input  logic              cmd_send_xoff,
  input  logic              txq_valid,
  input  logic [DATA_W-1:0] txq_data,
  output logic              txq_pop,
  input  logic              tx_busy,
  output logic              tx_start,
  output logic [DATA_W-1:0] tx_char,
  input  logic              cts_in,
  output logic              rts_out,
  output logic              dtr_out
);
  logic halted, hit_xon, hit_xoff;
  logic launch_data, launch_spec, pend_valid;

  sfc_inband u_inband (
    .clk(clk), .rst_n(rst_n), .en(cfg_inband_en),
    .xon_char(cfg_xon_char), .xoff_char(cfg_xoff_char),
    .rx_valid(rx_valid), .rx_char(rx_char),
    .fwd_wr(rx_fifo_wr), .fwd_data(rx_fifo_data),
    .hit_xon(hit_xon), .hit_xoff(hit_xoff), .halted(halted)
  );

  sfc_tx_sched u_sched (
    .clk(clk), .rst_n(rst_n), .halted(halted),
    .rts_cts_en(cfg_rts_cts_en), .cts_in(cts_in),
    .cmd_xon(cmd_send_xon), .cmd_xoff(cmd_send_xoff),
    .xon_char(cfg_xon_char), .xoff_char(cfg_xoff_char),
    .txq_valid(txq_valid), .txq_data(txq_data), .tx_busy(tx_busy),
    .tx_start(tx_start), .tx_char(tx_char), .txq_pop(txq_pop),
    .rts_out(rts_out), .launch_data(launch_data),
    .launch_spec(launch_spec), .pend_valid(pend_valid)
  );

  sfc_dtr_ctl u_dtr (
    .clk(clk), .rst_n(rst_n), .en(cfg_dtr_en),
    .thresh(cfg_rx_thresh), .level(rx_level), .dtr_out(dtr_out)
  );
endmodule

// File: rtl/sfc_flow_ctrl_chk.sv
module sfc_flow_ctrl_chk
  import sfc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_inband_en,
  input logic              cfg_rts_cts_en,
  input logic              cfg_dtr_en,
  input logic [DATA_W-1:0] cfg_xon_char,
  input logic [DATA_W-1:0] cfg_xoff_char,
  input logic              rx_valid,
  input logic [DATA_W-1:0] rx_char,
  input logic              rx_fifo_wr,
  input logic [LVL_W-1:0]  rx_level,
  input logic              txq_pop,
  input logic              tx_busy,
  input logic              tx_start,
  input logic              cts_in,
  input logic              rts_out,
  input logic              dtr_out,
  input logic              halted
);
  p_xoff_halts_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_inband_en && rx_valid && rx_char == cfg_xoff_char) |=> halted);

  p_halt_blocks_pop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> !txq_pop);

  p_xon_resumes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_inband_en && rx_valid && rx_char == cfg_xon_char &&
     rx_char != cfg_xoff_char) |=> !halted);

  p_code_dropped_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_inband_en && rx_valid &&
     (rx_char == cfg_xon_char || rx_char == cfg_xoff_char)) |-> !rx_fifo_wr);

  p_off_no_halt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_inband_en |=> !halted);

  p_cts_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rts_cts_en && !cts_in) |=> !tx_start);

  p_rts_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rts_cts_en |=> !rts_out);

  p_dtr_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dtr_en && int'(rx_level) >= FIFO_DEPTH) |=> !dtr_out);

  p_dtr_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_dtr_en |=> dtr_out);

  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start);

  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |=> !tx_start);

  p_pop_with_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    txq_pop |-> tx_start);
endmodule

bind sfc_flow_ctrl sfc_flow_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_inband_en(cfg_inband_en),
  .cfg_rts_cts_en(cfg_rts_cts_en), .cfg_dtr_en(cfg_dtr_en),
  .cfg_xon_char(cfg_xon_char), .cfg_xoff_char(cfg_xoff_char),
  .rx_valid(rx_valid), .rx_char(rx_char), .rx_fifo_wr(rx_fifo_wr),
  .rx_level(rx_level), .txq_pop(txq_pop), .tx_busy(tx_busy),
  .tx_start(tx_start), .cts_in(cts_in), .rts_out(rts_out),
  .dtr_out(dtr_out), .halted(halted)
);

// File: tb/sfc_flow_ctrl_tb_top.sv
module sfc_flow_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_inband_en = 1'b1, cfg_rts_cts_en = 1'b0, cfg_dtr_en = 1'b1;
  logic [7:0] cfg_xon_char = 8'h11, cfg_xoff_char = 8'h13;
  logic [3:0] cfg_rx_thresh = 4'd4;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_char = 8'h00;
  logic       rx_fifo_wr;
  logic [7:0] rx_fifo_data;
  logic [3:0] rx_level = 4'd0;
  logic       cmd_send_xon = 1'b0, cmd_send_xoff = 1'b0;
  logic       txq_valid, txq_pop;
  logic [7:0] txq_data;
  logic       tx_busy, tx_start;
  logic [7:0] tx_char;
  logic       cts_in = 1'b0;
  logic       rts_out, dtr_out;

  int checks = 0, fails = 0;
  int q_idx = 0, q_lim = 0;
  int busy_cnt = 0;
  logic [7:0] sent [0:15];
  int sent_n = 0;
  bit pop_on_code = 1'b0;

  always #10 clk = ~clk;

  assign txq_valid = q_idx < q_lim;
  assign txq_data  = 8'h40 + 8'(q_idx);
  assign tx_busy   = busy_cnt != 0;

  // Shifter and queue models
  always @(posedge clk) begin
    if (tx_start) begin
      busy_cnt <= 4;
      if (sent_n < 16) sent[sent_n] <= tx_char;
      sent_n <= sent_n + 1;
      if (txq_pop && (tx_char == cfg_xon_char || tx_char == cfg_xoff_char))
        pop_on_code <= 1'b1;
    end else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
    if (txq_pop) q_idx <= q_idx + 1;
  end

  sfc_flow_ctrl dut_i (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_log();
    sent_n = 0;
  endtask

  task automatic send_rx(input logic [7:0] c, input bit exp_fwd, input string tag);
    @(negedge clk);
    rx_valid = 1'b1; rx_char = c;
    #1;
    chk(rx_fifo_wr == exp_fwd && (!exp_fwd || rx_fifo_data == c), tag, rx_fifo_wr, exp_fwd);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!tx_start && !txq_pop && !rts_out && !dtr_out, "R10 reset outputs",
        {tx_start, txq_pop, rts_out, dtr_out}, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_basic();
    clear_log();
    q_lim = q_idx + 3;
    wait_cyc(25);
    chk(sent_n == 3, "R9 three queued chars sent", sent_n, 3);
    chk(sent[0] == 8'h40 && sent[2] == 8'h42, "R9 queue order", sent[2], 8'h42);
  endtask

  task automatic t_halt_resume();
    int base;
    send_rx(8'h13, 1'b0, "R3 stop code dropped");
    send_rx(8'h55, 1'b1, "R3 plain char forwarded");
    clear_log();
    base = q_idx;
    q_lim = q_idx + 2;
    wait_cyc(20);
    chk(sent_n == 0 && q_idx == base, "R1 halted blocks data", sent_n, 0);
    send_rx(8'h11, 1'b0, "R3 resume code dropped");
    wait_cyc(20);
    chk(sent_n == 2, "R2 data resumes", sent_n, 2);
    chk(sent[0] == 8'h40 + 8'(base), "R2 resume order", sent[0], 8'h40 + base);
  endtask

  task automatic t_code_while_halted();
    send_rx(8'h13, 1'b0, "R3 stop code dropped again");
    clear_log();
    q_lim = q_idx + 1;
    @(negedge clk); cmd_send_xon = 1'b1;
    @(negedge clk); cmd_send_xon = 1'b0;
    wait_cyc(15);
    chk(sent_n == 1 && sent[0] == 8'h11, "R5 code sent while halted", sent_n, 1);
    chk(!pop_on_code, "R5 no pop on code", pop_on_code, 0);
    send_rx(8'h11, 1'b0, "R3 resume");
    wait_cyc(10);
    chk(sent_n == 2, "R2 queued char after resume", sent_n, 2);
  endtask

  task automatic t_cts_priority();
    cfg_rts_cts_en = 1'b1; cts_in = 1'b0;
    clear_log();
    q_lim = q_idx + 2;
    @(negedge clk); cmd_send_xon = 1'b1; cmd_send_xoff = 1'b1;
    @(negedge clk); cmd_send_xon = 1'b0; cmd_send_xoff = 1'b0;
    wait_cyc(10);
    chk(sent_n == 0, "R6 CTS low blocks all", sent_n, 0);
    chk(rts_out == 1'b1, "R7 RTS raised while pending", rts_out, 1);
    cts_in = 1'b1;
    wait_cyc(20);
    chk(sent_n == 3, "R6 sends after CTS", sent_n, 3);
    chk(sent[0] == 8'h13, "R5 stop code first, wins tie", sent[0], 8'h13);
    wait_cyc(3);
    chk(rts_out == 1'b0, "R7 RTS drops when idle", rts_out, 0);
    cfg_rts_cts_en = 1'b0; cts_in = 1'b0;
    clear_log();
    q_lim = q_idx + 1;
    wait_cyc(10);
    chk(sent_n == 1, "R6 CTS ignored when disabled", sent_n, 1);
    chk(rts_out == 1'b0, "R7 RTS low when disabled", rts_out, 0);
  endtask

  task automatic t_inband_off();
    cfg_inband_en = 1'b0;
    send_rx(8'h13, 1'b1, "R4 stop code forwarded when off");
    clear_log();
    q_lim = q_idx + 1;
    wait_cyc(10);
    chk(sent_n == 1, "R4 no halt when off", sent_n, 1);
    cfg_inband_en = 1'b1;
  endtask

  task automatic dtr_case(input logic [3:0] th, input logic [3:0] lv, input bit exp, input string tag);
    @(negedge clk);
    cfg_rx_thresh = th; rx_level = lv;
    @(negedge clk);
    chk(dtr_out == exp, tag, dtr_out, exp);
  endtask

  task automatic t_dtr();
    dtr_case(4'd3, 4'd2, 1'b1, "R8 below threshold");
    dtr_case(4'd3, 4'd3, 1'b0, "R8 at threshold");
    dtr_case(4'd0, 4'd0, 1'b1, "R8 zero acts as one, empty");
    dtr_case(4'd0, 4'd1, 1'b0, "R8 zero acts as one, level 1");
    dtr_case(4'd12, 4'd7, 1'b1, "R8 limit 8, level 7");
    dtr_case(4'd12, 4'd8, 1'b0, "R8 limit 8, level 8");
    cfg_dtr_en = 1'b0;
    dtr_case(4'd2, 4'd8, 1'b1, "R8 disabled holds high");
    cfg_dtr_en = 1'b1;
  endtask

  initial begin
    fork
      begin
        wait_cyc(2);
        t_reset();
        wait_cyc(2);
        t_basic();
        t_halt_resume();
        t_code_while_halted();
        t_cts_priority();
        t_inband_off();
        t_dtr();
      end
      begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule